// File: doc/BRIEF.md
# Synchronized debug serial port

This block is the target side of a slow serial link that an external debugger uses to exchange fixed-length packets with on-chip debug logic. The debugger's serial clock and data lines are asynchronous to the core clock. Both lines pass through a synchronizer chain. The serial clock is then filtered: a new level is accepted only when it holds for two consecutive core clock samples. Each accepted rising edge of the serial clock shifts one received bit in and moves the serial output to its next response bit.

A packet has 17 bits and is sent most significant bit first. The leading bit is a status/control flag and the other sixteen are data. After the last bit the block presents the received word with a one-cycle valid strobe to a command decoder. The decoder can queue a response word, which is shifted out during the next packet. If no response was queued, a fixed "not ready" word goes out instead. The debugger must give each serial clock period at least five core clock cycles.

Top module: `dbg_serial_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sdo_o` is 0, `rx_valid_o` is 0 and `rx_word_o` is 0. The bit counter and the queued response are cleared, so a reset in the middle of a packet makes the next packet start at bit 0 and carry the "not ready" word.
- R2: After synchronization, the serial clock counts as a new level only when two consecutive core clock samples agree. A high pulse lasting one core cycle moves neither the counter nor `sdo_o`.
- R3: `sdi_i` is sampled once for each validated rising edge of the serial clock. A change on `sdi_i` while the serial clock stays high has no effect on the received word.
- R4: `sdo_o` is registered and changes only on a validated rising edge. Each such edge advances it by one response bit, starting with bit 16 on the first edge of a packet.
- R5: A packet is 17 bits, most significant bit first. One core cycle after the 17th validated edge, `rx_valid_o` is high for exactly one cycle, and `rx_word_o` then holds the 17 received bits, with the first bit received in bit 16.
- R6: A pulse on `tx_load_i` captures `tx_data_i`, and that word is shifted out most significant bit first during the next packet. It is used only once.
- R7: When no word is queued at the start of a packet, the port shifts out 17'h10000 (bit 16 set, all other bits 0).
- R8: With the default two synchronizer stages, `sdo_o` updates on the fourth core clock rising edge after `sclk_i` goes high. It is unchanged after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Debugger serial clock, asynchronous |
| sdi_i | input | 1 | Debugger serial data in, asynchronous |
| sdo_o | output | 1 | Registered serial data out |
| rx_valid_o | output | 1 | One-cycle strobe: received packet available |
| rx_word_o | output | 17 | Last received packet |
| tx_load_i | input | 1 | Queue a response word |
| tx_data_i | input | 17 | Response word to queue |

## Verification
On every cycle the assertions check three things. The filtered clock level holds whenever two consecutive synchronized samples disagree. The serial output moves only on an accepted rising edge. The packet strobe is a single-cycle pulse that follows the last bit, and the counter stays in range. Only the bench scenarios can show the rest, because each spans a whole packet: the bit order of received and transmitted words, the four-edge output latency, the rejection of one-cycle glitches and of data changes during the high phase, the single use of a queued response, and recovery from a reset mid-packet.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int DEF_PKT_W    = 17;
  localparam int DEF_SYNC_STG = 2;
endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_d[g] = async_i;
    end else begin : g_rest
      assign stg_d[g] = stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsp_edge.sv
module dsp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  output logic rise_o
);
  logic prev_q, filt_q;
  logic agree, filt_d;

  always_comb begin
    agree  = (smp_i == prev_q);
    filt_d = agree ? smp_i : filt_q;
    rise_o = agree & smp_i & ~filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      filt_q <= filt_d;
    end
  end

  // R2
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_i != prev_q) |=> (filt_q == $past(filt_q)));

  // R2
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> ($past(smp_i) && $past(prev_q)));
endmodule

// File: rtl/dsp_shifter.sv
module dsp_shifter #(
  parameter int             PKT_W   = 17,
  parameter logic [PKT_W-1:0] NR_WORD = {1'b1, {(PKT_W-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             sdi_i,
  input  logic             load_i,
  input  logic [PKT_W-1:0] data_i,
  output logic             sdo_o,
  output logic             vld_o,
  output logic [PKT_W-1:0] word_o
);
  localparam int CNT_W = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-1:0] rx_q, rx_d, tx_q, tx_d, word_q, word_d, hold_q, hold_d;
  logic [PKT_W-1:0] src;
  logic             sdo_q, sdo_d, vld_q, vld_d, pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    sdo_d  = sdo_q;
    vld_d  = 1'b0;
    word_d = word_q;
    hold_d = hold_q;
    pend_d = pend_q;
    src    = pend_q ? hold_q : NR_WORD;
    if (rise_i) begin
      rx_d = {rx_q[PKT_W-2:0], sdi_i};
      if (cnt_q == '0) begin
        sdo_d  = src[PKT_W-1];
        tx_d   = {src[PKT_W-2:0], 1'b0};
        pend_d = 1'b0;
      end else begin
        sdo_d = tx_q[PKT_W-1];
        tx_d  = {tx_q[PKT_W-2:0], 1'b0};
      end
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        vld_d  = 1'b1;
        word_d = {rx_q[PKT_W-2:0], sdi_i};
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    if (load_i) begin
      hold_d = data_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      sdo_q  <= 1'b0;
      vld_q  <= 1'b0;
      word_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      sdo_q  <= sdo_d;
      vld_q  <= vld_d;
      word_q <= word_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign sdo_o  = sdo_q;
  assign vld_o  = vld_q;
  assign word_o = word_q;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R5
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> ($past(rise_i) && ($past(cnt_q) == LAST)));

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(sdo_q));
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dsp_pkg::*;
#(
  parameter int PKT_W       = DEF_PKT_W,
  parameter int SYNC_STAGES = DEF_SYNC_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             rx_valid_o,
  output logic [PKT_W-1:0] rx_word_o,
  input  logic             tx_load_i,
  input  logic [PKT_W-1:0] tx_data_i
);
  localparam logic [PKT_W-1:0] NR_WORD = {1'b1, {(PKT_W-1){1'b0}}};

  logic [1:0] synced;
  logic       rise;

  dsp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sclk_i, sdi_i}),
    .sync_o  (synced)
  );

  dsp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_i  (synced[1]),
    .rise_o (rise)
  );

  dsp_shifter #(.PKT_W(PKT_W), .NR_WORD(NR_WORD)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .sdi_i  (synced[0]),
    .load_i (tx_load_i),
    .data_i (tx_data_i),
    .sdo_o  (sdo_o),
    .vld_o  (rx_valid_o),
    .word_o (rx_word_o)
  );
endmodule

// File: tb/sim_dbg_serial_port.sv
`timescale 1ns/1ps
module sim_dbg_serial_port;
  localparam int W = 17;
  localparam logic [W-1:0] NR = 17'h10000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sclk, sdi, sdo, rxv, tx_load;
  logic [W-1:0] rx_word, tx_data;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] rxq[$];

  always #5 clk = ~clk;

  dbg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .rx_valid_o(rxv), .rx_word_o(rx_word), .tx_load_i(tx_load), .tx_data_i(tx_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected received words as strobes appear
  always @(negedge clk) begin
    if (rst_n && rxv) begin
      if (rxq.size() == 0) check("R5 unexpected strobe", 17'h1, 17'h0);
      else check("R5 R3 rx word", rx_word, rxq.pop_front());
    end
  end

  task automatic load(input logic [W-1:0] d);
    @(negedge clk); tx_load = 1'b1; tx_data = d;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] din, input logic [W-1:0] exp_tx,
                      input bit lat, input bit wiggle);
    logic [W-1:0] got;
    logic prev;
    rxq.push_back(din);
    for (int i = W-1; i >= 0; i--) begin
      sdi = din[i];
      repeat (HALF) @(negedge clk);
      prev = sdo;
      sclk = 1'b1;
      if (lat && i == W-1) begin
        repeat (3) @(negedge clk);
        check("R8 sdo before 4th edge", {16'h0, sdo}, {16'h0, prev});
        @(negedge clk);
        check("R8 sdo after 4th edge", {16'h0, sdo}, {16'h0, exp_tx[i]});
      end else begin
        repeat (4) @(negedge clk);
      end
      if (wiggle) sdi = ~din[i];
      repeat (HALF-4) @(negedge clk);
      got[i] = sdo;
      sclk = 1'b0;
    end
    check("R4 R6 R7 tx word", got, exp_tx);
  endtask

  task automatic bits_only(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic s0;
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; tx_load = 1'b0; tx_data = '0;
    repeat (4) @(negedge clk);
    check("R1 sdo reset", {16'h0, sdo}, 17'h0);
    check("R1 rx_valid reset", {16'h0, rxv}, 17'h0);
    check("R1 rx_word reset", rx_word, 17'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 latency and R6 queued response
    load(17'h1A5C3);
    send(17'h0F0F1, 17'h1A5C3, 1'b1, 1'b0);
    // R7 nothing queued
    send(17'h1FFFF, NR, 1'b0, 1'b0);
    // R6 used once
    load(17'h05555);
    send(17'h00001, 17'h05555, 1'b0, 1'b0);
    send(17'h10000, NR, 1'b0, 1'b0);

    // R2 one-cycle glitches are ignored
    repeat (HALF) @(negedge clk);
    s0 = sdo;
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; @(negedge clk); sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    check("R2 sdo after glitches", {16'h0, sdo}, {16'h0, s0});
    load(17'h0BEEF);
    send(17'h12345, 17'h0BEEF, 1'b0, 1'b0);

    // R3 data changes during high phase ignored
    load(17'h1CAFE);
    send(17'h0ACE5, 17'h1CAFE, 1'b0, 1'b1);

    // R1 reset mid-packet
    load(17'h1FFFF);
    bits_only(5);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 sdo mid reset", {16'h0, sdo}, 17'h0);
    check("R1 rx_valid mid reset", {16'h0, rxv}, 17'h0);
    check("R1 rx_word mid reset", rx_word, 17'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(17'h1C3A9, NR, 1'b0, 1'b0);

    // R5 back-to-back packets
    load(17'h1FFFF);
    send(17'h00000, 17'h1FFFF, 1'b0, 1'b0);
    load(17'h00000);
    send(17'h15A5A, 17'h00000, 1'b0, 1'b0);

    repeat (HALF) @(negedge clk);
    check("R5 all packets seen", 17'(rxq.size()), 17'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule